// File: doc/BRIEF.md
# Deferred Coefficient Commit Controller

This block lets a control processor stage a small group of coefficient updates and have them land in the coefficient memories all together, while the signal-processing core is not reading those memories. Each of the five slots holds a destination address and a data word. The host fills the slots through a register write port. A trigger pulse arms the block. At the next frame-start idle window reported by the core, the block sweeps the slots in index order. Every slot that was loaded is written to the RAM write port in a single burst, so one filter section's coefficients change within one frame.

Two destinations are accepted. The first is the parameter RAM, at addresses 0 to 1023. It receives the low 28 bits of the data word, a signed 5.23 fraction. The second is the ramp-target RAM, at addresses 2560 to 2623. It receives all 34 stored bits. Any other address is refused: this covers the program RAM, the control registers and anything above. A refused slot is dropped, and a flag is raised during its slot cycle. While the sweep is running, host writes are refused with a stall indication, so a slot can never be half-updated.

Top module: `safeload_ctrl`

## Requirements
- R1: After reset, busy, reg_stall, ram_we and drop are 0 and no slot is loaded, so a commit run on a freshly reset block writes nothing.
- R2: With reg_wr high and reg_is_addr = 0, reg_wdata (34 bits) is stored as the data word of slot reg_idx. With reg_is_addr = 1, reg_wdata[15:0] is stored as the slot's address and the slot becomes loaded. Writes with reg_idx of 5 or more change no slot.
- R3: A trigger pulse arms the block. The sweep starts on the first clock edge at which the block is armed and frame_idle is high. It occupies exactly 5 consecutive cycles, with slot k presented in the k-th cycle. A frame_idle pulse while not armed does nothing.
- R4: Only loaded slots produce a RAM write or a drop, and they are handled in ascending slot index order.
- R5: A loaded slot whose address is 0..1023 gives ram_we = 1, ram_slew = 0, ram_addr = address[11:0] and ram_wdata = {6'b0, data[27:0]}.
- R6: A loaded slot whose address is 2560..2623 gives ram_we = 1, ram_slew = 1, ram_addr = address[11:0] and ram_wdata = data[33:0].
- R7: A loaded slot with any other 16-bit address (1024..2559 or 2624..65535) gives ram_we = 0 and drop = 1 in its slot cycle.
- R8: After a sweep every slot is unloaded, so a second trigger with no new address writes produces no RAM writes.
- R9: During the sweep reg_stall is 1, and host writes are ignored: the slot contents seen by a later commit are unchanged by them.
- R10: busy is 1 from the cycle after the trigger until the last sweep cycle, and 0 after it. A trigger during the sweep does not re-arm the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_is_addr | input | 1 | 1 selects a slot's address register, 0 its data register |
| reg_idx | input | 3 | Slot index of the write |
| reg_wdata | input | 34 | Write value (address uses bits 15:0) |
| reg_stall | output | 1 | Host writes are refused this cycle |
| trigger | input | 1 | Arm-commit pulse |
| frame_idle | input | 1 | Core reports the frame-start idle window |
| busy | output | 1 | Armed or sweeping |
| ram_we | output | 1 | RAM write enable |
| ram_slew | output | 1 | 1 selects the ramp-target RAM, 0 the parameter RAM |
| ram_addr | output | 12 | RAM write address |
| ram_wdata | output | 34 | RAM write data |
| drop | output | 1 | Current slot is loaded but its address is refused |

## Verification
The bench builds the block with its default values: five slots, a parameter range of 1024 words, and a ramp range of 64 words based at 2560. Those settings make it practical to sweep all 32 combinations of loaded slots. Destination addresses for each sweep are computed so that every slot visits both accepted ranges and both refused ranges. A directed round covers every range edge and an address with high bits set. Host writes and triggers are also injected during sweeps.

// File: rtl/safeload_pkg.sv
package safeload_pkg;

    parameter int SL_DATA_W    = 34;   // stored data bits (ramp RAM width)
    parameter int SL_PARAM_DW  = 28;   // parameter RAM word, 5.23 signed
    parameter int SL_REGADDR_W = 16;   // slot address register width
    parameter int SL_RAM_AW    = 12;   // RAM write address width

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARMED,
        SEQ_RUN
    } sl_state_t;

    typedef enum logic [1:0] {
        DST_NONE,
        DST_PARAM,
        DST_SLEW,
        DST_REFUSE
    } sl_dest_t;

    typedef struct packed {
        logic                    valid;
        logic [SL_REGADDR_W-1:0] addr;
        logic [SL_DATA_W-1:0]    data;
    } sl_slot_t;

    // Decide where a slot goes; program/control space and beyond are refused.
    function automatic sl_dest_t sl_classify(
        input logic                    loaded,
        input logic [SL_REGADDR_W-1:0] addr,
        input int unsigned             param_depth,
        input int unsigned             slew_base,
        input int unsigned             slew_depth
    );
        int unsigned a;
        a = {{(32-SL_REGADDR_W){1'b0}}, addr};
        if (!loaded)
            return DST_NONE;
        if (a < param_depth)
            return DST_PARAM;
        if (a >= slew_base && a < slew_base + slew_depth)
            return DST_SLEW;
        return DST_REFUSE;
    endfunction

endpackage

// File: rtl/safeload_slot_bank.sv
module safeload_slot_bank
    import safeload_pkg::*;
#(
    parameter int N     = 5,
    parameter int IDX_W = 3,
    parameter int PTR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_is_addr,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [SL_DATA_W-1:0] wr_data,
    input  logic                 clr_en,
    input  logic [PTR_W-1:0]     clr_idx,
    output sl_slot_t [N-1:0]     slots
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        sl_slot_t slot_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else begin
                if (clr_en && clr_idx == PTR_W'(g))
                    slot_q.valid <= 1'b0;
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    if (wr_is_addr) begin
                        slot_q.addr  <= wr_data[SL_REGADDR_W-1:0];
                        slot_q.valid <= 1'b1;
                    end else begin
                        slot_q.data  <= wr_data;
                    end
                end
            end
        end

        // A slot is never loaded and swept in the same cycle
        AST_NO_WRITE_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_idx == PTR_W'(g)) |-> !(wr_en && wr_idx == IDX_W'(g))); // R9

        assign slots[g] = slot_q;
    end

endmodule

// File: rtl/safeload_sequencer.sv
module safeload_sequencer
    import safeload_pkg::*;
#(
    parameter int N     = 5,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trigger,
    input  logic             frame_idle,
    output logic             armed,
    output logic             running,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

    sl_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            ptr     <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (trigger)
                        state_q <= SEQ_ARMED;
                end
                SEQ_ARMED: begin
                    if (frame_idle) begin
                        state_q <= SEQ_RUN;
                        ptr     <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (ptr == LAST) begin
                        state_q <= SEQ_IDLE;
                        ptr     <= '0;
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign armed   = (state_q == SEQ_ARMED);
    assign running = (state_q == SEQ_RUN);

    AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> ($past(armed) && $past(frame_idle))); // R3
    AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (running && ptr == LAST) |=> !running); // R3
    AST_SWEEP_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> ptr == PTR_W'($past(ptr) + 1'b1)); // R4

endmodule

// File: rtl/safeload_emitter.sv
module safeload_emitter
    import safeload_pkg::*;
#(
    parameter int N           = 5,
    parameter int PTR_W       = 3,
    parameter int PARAM_DEPTH = 1024,
    parameter int SLEW_BASE   = 2560,
    parameter int SLEW_DEPTH  = 64
) (
    input  sl_slot_t [N-1:0]     slots,
    input  logic                 running,
    input  logic [PTR_W-1:0]     ptr,
    output logic                 ram_we,
    output logic                 ram_slew,
    output logic [SL_RAM_AW-1:0] ram_addr,
    output logic [SL_DATA_W-1:0] ram_wdata,
    output logic                 drop
);

    sl_slot_t cur;
    sl_dest_t dest;

    always_comb begin
        cur = '0;
        if (int'(ptr) < N)
            cur = slots[ptr];
        dest = running ? sl_classify(cur.valid, cur.addr, PARAM_DEPTH, SLEW_BASE, SLEW_DEPTH)
                       : DST_NONE;
        ram_we   = (dest == DST_PARAM) || (dest == DST_SLEW);
        ram_slew = (dest == DST_SLEW);
        drop     = (dest == DST_REFUSE);
        ram_addr = cur.addr[SL_RAM_AW-1:0];
        if (dest == DST_SLEW)
            ram_wdata = cur.data;
        else
            ram_wdata = {{(SL_DATA_W-SL_PARAM_DW){1'b0}}, cur.data[SL_PARAM_DW-1:0]};
    end

endmodule

// File: rtl/safeload_ctrl.sv
module safeload_ctrl
    import safeload_pkg::*;
#(
    parameter int NUM_SLOTS   = 5,
    parameter int IDX_W       = 3,
    parameter int PARAM_DEPTH = 1024,
    parameter int SLEW_BASE   = 2560,
    parameter int SLEW_DEPTH  = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_is_addr,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [SL_DATA_W-1:0] reg_wdata,
    output logic                 reg_stall,
    input  logic                 trigger,
    input  logic                 frame_idle,
    output logic                 busy,
    output logic                 ram_we,
    output logic                 ram_slew,
    output logic [SL_RAM_AW-1:0] ram_addr,
    output logic [SL_DATA_W-1:0] ram_wdata,
    output logic                 drop
);

    localparam int PTR_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic                       armed;
    logic                       running;
    logic [PTR_W-1:0]           ptr;
    sl_slot_t [NUM_SLOTS-1:0]   slots;
    logic [NUM_SLOTS-1:0]       loaded_vec;

    safeload_sequencer #(.N(NUM_SLOTS), .PTR_W(PTR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .trigger    (trigger),
        .frame_idle (frame_idle),
        .armed      (armed),
        .running    (running),
        .ptr        (ptr)
    );

    safeload_slot_bank #(.N(NUM_SLOTS), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr && !running),
        .wr_is_addr (reg_is_addr),
        .wr_idx     (reg_idx),
        .wr_data    (reg_wdata),
        .clr_en     (running),
        .clr_idx    (ptr),
        .slots      (slots)
    );

    safeload_emitter #(
        .N(NUM_SLOTS), .PTR_W(PTR_W), .PARAM_DEPTH(PARAM_DEPTH),
        .SLEW_BASE(SLEW_BASE), .SLEW_DEPTH(SLEW_DEPTH)
    ) u_emit (
        .slots     (slots),
        .running   (running),
        .ptr       (ptr),
        .ram_we    (ram_we),
        .ram_slew  (ram_slew),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .drop      (drop)
    );

    assign reg_stall = running;
    assign busy      = armed || running;

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++)
            loaded_vec[i] = slots[i].valid;
    end

    AST_WRITE_ONLY_IN_SWEEP: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (reg_stall && busy)); // R3
    AST_PARAM_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !ram_slew) |-> ram_wdata[SL_DATA_W-1:SL_PARAM_DW] == '0); // R5
    AST_PARAM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !ram_slew) |-> int'(ram_addr) < PARAM_DEPTH); // R5
    AST_SLEW_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ram_slew) |-> (int'(ram_addr) >= SLEW_BASE &&
                                  int'(ram_addr) < SLEW_BASE + SLEW_DEPTH)); // R6
    AST_WRITE_OR_DROP: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_we, drop})); // R7
    AST_SLOTS_EMPTY_AFTER: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> loaded_vec == '0); // R8
    AST_TRIGGER_ARMS: assert property (@(posedge clk) disable iff (rst)
        (trigger && !busy) |=> busy); // R10

endmodule

// File: tb/sim_safeload_ctrl.sv
module sim_safeload_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_is_addr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [33:0] reg_wdata = '0;
    logic        reg_stall;
    logic        trigger = 1'b0;
    logic        frame_idle = 1'b0;
    logic        busy;
    logic        ram_we;
    logic        ram_slew;
    logic [11:0] ram_addr;
    logic [33:0] ram_wdata;
    logic        drop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_addr [5];
    logic [33:0] m_data [5];
    bit          m_valid [5];

    always #4 clk = ~clk;

    safeload_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_is_addr(reg_is_addr),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_stall(reg_stall),
        .trigger(trigger), .frame_idle(frame_idle), .busy(busy),
        .ram_we(ram_we), .ram_slew(ram_slew), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .drop(drop)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit is_addr, input int idx, input logic [33:0] val);
        reg_wr = 1'b1; reg_is_addr = is_addr; reg_idx = 3'(idx); reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
        if (idx < 5) begin
            if (is_addr) begin m_addr[idx] = val[15:0]; m_valid[idx] = 1'b1; end
            else m_data[idx] = val;
        end
    endtask

    // expected {we, slew, drop, addr, wdata} for one slot, plus its requirement tag
    function automatic logic [63:0] exp_slot(input int k, output string tag);
        int a;
        a = int'(m_addr[k]);
        tag = "R4";
        if (!m_valid[k]) return '0;
        if (a < 1024) begin
            tag = "R5";
            return {15'b0, 3'b100, m_addr[k][11:0], 6'b0, m_data[k][27:0]};
        end
        if (a >= 2560 && a < 2624) begin
            tag = "R6";
            return {15'b0, 3'b110, m_addr[k][11:0], m_data[k]};
        end
        tag = "R7";
        return {15'b0, 3'b001, 46'b0};
    endfunction

    task automatic do_commit(input string pre);
        string tag;
        logic [63:0] e;
        logic [63:0] a;
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        chk({pre, " R10 busy after trigger"}, 64'(busy), 64'd1);
        chk({pre, " R3 no write while armed"}, 64'({ram_we, drop}), 64'd0);
        repeat (2) @(negedge clk);
        chk({pre, " R3 waits for idle window"}, 64'({busy, reg_stall}), 64'b10);
        frame_idle = 1'b1;
        @(negedge clk);
        frame_idle = 1'b0;
        for (int k = 0; k < 5; k++) begin
            e = exp_slot(k, tag);
            a = {15'b0, ram_we, ram_slew, drop, ram_addr, ram_wdata};
            if (!ram_we) a[45:0] = '0;
            chk({pre, " ", tag, " slot output"}, a, e);
            chk({pre, " R9 stall during sweep"}, 64'({reg_stall, busy}), 64'b11);
            if (k == 0) begin
                // ignored host write and trigger during the sweep
                reg_wr = 1'b1; reg_is_addr = 1'b0; reg_idx = 3'd0; reg_wdata = 34'h2BADBEEF1;
                trigger = 1'b1;
            end else if (k == 1) begin
                reg_wr = 1'b0; trigger = 1'b0;
            end
            @(negedge clk);
        end
        chk({pre, " R10 idle after sweep"}, 64'({busy, reg_stall, ram_we, drop}), 64'd0);
        for (int k = 0; k < 5; k++) m_valid[k] = 1'b0;
    endtask

    function automatic logic [15:0] gen_addr(input int r, input int i);
        case ((r + i) % 5)
            0: return 16'((r * 37 + i * 101) % 1024);
            1: return 16'(2560 + (r * 7 + i * 13) % 64);
            2: return 16'(1024 + (r * 53 + i * 29) % 1536);
            3: return 16'(2624 + (r * 97 + i) % 3000);
            default: return 16'((r * 11 + i) % 1024);
        endcase
    endfunction

    function automatic logic [33:0] gen_data(input int r, input int i);
        logic [63:0] v;
        v = 64'(r) * 64'd2654435761 + 64'(i) * 64'd40503 + 64'h3_0000_0005;
        return v[33:0];
    endfunction

    initial begin
        for (int k = 0; k < 5; k++) begin m_addr[k] = '0; m_data[k] = '0; m_valid[k] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset busy", 64'(busy), 64'd0);
        chk("R1 reset stall", 64'(reg_stall), 64'd0);
        chk("R1 reset ram_we", 64'(ram_we), 64'd0);
        chk("R1 reset drop", 64'(drop), 64'd0);
        do_commit("R1 empty");

        frame_idle = 1'b1;
        @(negedge clk);
        frame_idle = 1'b0;
        @(negedge clk);
        chk("R3 idle window unarmed", 64'({busy, ram_we}), 64'd0);

        // R2: slots 5..7 are not real; writes there change nothing
        for (int i = 5; i < 8; i++) wr(1'b1, i, 34'd100);
        do_commit("R2 out-of-range index");

        for (int r = 0; r < 32; r++) begin
            for (int i = 0; i < 5; i++) begin
                wr(1'b0, i, gen_data(r, i));
                if (r[i]) wr(1'b1, i, 34'(gen_addr(r, i)));
            end
            do_commit("R2 sweep");
        end

        // boundary addresses
        wr(1'b1, 0, 34'd0);    wr(1'b1, 1, 34'd1023); wr(1'b1, 2, 34'd1024);
        wr(1'b1, 3, 34'd2559); wr(1'b1, 4, 34'd2560);
        do_commit("R7 edges a");
        wr(1'b1, 0, 34'd2623); wr(1'b1, 1, 34'd2624); wr(1'b1, 2, 34'hFFFF);
        wr(1'b1, 3, 34'h1A00); wr(1'b1, 4, 34'd512);
        do_commit("R7 edges b");
        do_commit("R8 second trigger");

        // R9: the data write attempted during the previous sweeps must not have landed
        wr(1'b0, 0, 34'h3_1234_5678);
        wr(1'b1, 0, 34'd5);
        do_commit("R9 prime");
        wr(1'b1, 0, 34'd7);
        do_commit("R9 held data");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog act=hung exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule